// File: doc/BRIEF.md
# Maskable Event and Stop Controller

This block collects event flags for a small processing core and decides, every cycle, whether the core may keep running. Each event line sets a sticky pending bit. Software chooses which events matter through a per-bit enable mask. It can read the pending set at any time without side effects. It can also hold a wait request, which stalls the core until an enabled event is pending. With the vector enable bit set, an enabled pending event steers instruction fetch to local address zero for one cycle. The enable bit then drops by itself, so the handler runs with further vectoring off until software turns it back on.

The block also handles the core's fatal conditions. An illegal instruction or a stop-and-signal instruction stops the core in the same cycle. The block records a cause code in a status register and raises a level interrupt toward a host processor. A write to the interrupt mailbox channel also raises the host interrupt, but the core keeps running. The host restarts the core through a restart bit and removes the interrupt through a separate clear bit. The core pipeline itself lies outside this block.

Top module: `evt_stop_ctrl`

## Requirements
- R1: A 1 on evt_in[i] in a cycle makes pending bit i read 1 from the next cycle on. The bit stays set until it is acknowledged, whatever the mask.
- R2: Writing address 2 (acknowledge, write-only, reads 0) clears each pending bit whose data bit is 1. If an event arrives in the same cycle, the event wins and its bit stays set.
- R3: Address 0 holds the read/write enable mask (bit i = 1 enables event i). stall_o is 1 exactly when wait_i is 1 and no pending bit is also enabled. Writing the mask to enable an already pending event lifts the stall in the next cycle.
- R4: While waiting, an enabled event seen at evt_in in cycle t leaves stall_o at 1 in cycle t and drops it to 0 in cycle t+1.
- R5: Address 1 returns the pending bits, masked ones included, and reading it changes no state.
- R6: Address 3 bit 0 is the vector enable. When it is 1, an enabled event is pending and the core is not halted, redirect_o is 1 for one cycle with redirect_pc_o = 0. The enable bit then reads 0 and no further redirect follows. Masked events and a halted core never redirect.
- R7: illegal_i = 1 drives halt_o to 1 in the same cycle. From the next cycle on, address 4 reads bit 0 (stopped) = 1 and bits 2:1 (cause) = 1, and irq_o = 1.
- R8: stop_i = 1 halts the core in the same way with cause 2. If illegal_i and stop_i arrive together, cause 1 is recorded.
- R9: mbox_i = 1 on a running core sets status bit 3 and irq_o from the next cycle, without halting.
- R10: Writing status with bit 4 = 1 clears the stopped flag and halt_o, but keeps the cause and irq_o. Writing bit 5 = 1 clears the cause and bit 3, which drops irq_o.
- R11: While the core is halted, illegal_i, stop_i and mbox_i are ignored and the recorded status is kept.
- R12: After reset, mask, pending, vector enable and status all read 0, and stall_o, redirect_o, halt_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | NUM_EVT | Event flags, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wait_i | input | 1 | Core requests to wait for an event |
| stall_o | output | 1 | Core must hold |
| redirect_o | output | 1 | Fetch must jump to the vector |
| redirect_pc_o | output | PC_W | Vector address (always zero) |
| illegal_i | input | 1 | Core decoded an illegal instruction |
| stop_i | input | 1 | Core executed stop-and-signal |
| mbox_i | input | 1 | Core wrote the interrupt mailbox channel |
| halt_o | output | 1 | Core is stopped |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The assertions assume that a halted core does not keep issuing illegal, stop or mailbox pulses. They also assume the host uses the register port only at the five decoded addresses. The stimulus drives each exception as a single-cycle pulse and leaves it low otherwise, except for the one deliberate pulse sent while halted. It applies register writes one at a time, between half-cycle samples. Collisions that the requirements define, such as an event arriving together with its acknowledge or both exception inputs rising together, are set up on purpose in a single cycle.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int REG_AW = 3;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] ADDR_MASK = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_PEND = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_ACK  = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_CTRL = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_STAT = 3'd4;

    localparam int ST_STOPPED = 0;
    localparam int ST_CAUSE   = 1;
    localparam int ST_MBOX    = 3;
    localparam int ST_RESTART = 4;
    localparam int ST_CLEAR   = 5;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_ILLEGAL = 2'd1,
        CAUSE_STOP    = 2'd2
    } cause_e;

    typedef struct packed {
        logic   halted;
        cause_e cause;
        logic   mbox;
    } stop_st_t;
endpackage

// File: rtl/evc_event_bank.sv
module evc_event_bank #(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               mask_we,
    input  logic [NUM_EVT-1:0] mask_wdata,
    input  logic               ack_we,
    input  logic [NUM_EVT-1:0] ack_wdata,
    input  logic               ie_we,
    input  logic               ie_wdata,
    input  logic               halted,
    output logic [NUM_EVT-1:0] pend_o,
    output logic [NUM_EVT-1:0] mask_o,
    output logic               int_en_o,
    output logic               hit_o,
    output logic               take_o
);
    typedef struct packed {
        logic [NUM_EVT-1:0] pend;
        logic [NUM_EVT-1:0] mask;
        logic               int_en;
    } bank_st_t;

    bank_st_t           st_d, st_q;
    logic [NUM_EVT-1:0] pend_nx;
    logic               hit;
    logic               take;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        assign pend_nx[i] = evt_in[i] | (st_q.pend[i] & ~(ack_we & ack_wdata[i]));
    end

    assign hit  = |(st_q.pend & st_q.mask);
    assign take = st_q.int_en & hit & ~halted;

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_nx;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
        if (take) begin
            st_d.int_en = 1'b0;
        end else if (ie_we) begin
            st_d.int_en = ie_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o   = st_q.pend;
    assign mask_o   = st_q.mask;
    assign int_en_o = st_q.int_en;
    assign hit_o    = hit;
    assign take_o   = take;
endmodule

// File: rtl/evc_stop_unit.sv
module evc_stop_unit
    import evc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   illegal_i,
    input  logic   stop_i,
    input  logic   mbox_i,
    input  logic   restart,
    input  logic   clr,
    output logic   halted_o,
    output cause_e cause_o,
    output logic   mbox_o,
    output logic   exc_now_o
);
    stop_st_t st_d, st_q;
    logic     exc_take;
    logic     mbox_take;

    assign exc_take  = (illegal_i | stop_i) & ~st_q.halted;
    assign mbox_take = mbox_i & ~st_q.halted;

    always_comb begin
        st_d = st_q;
        if (exc_take) begin
            st_d.halted = 1'b1;
            st_d.cause  = illegal_i ? CAUSE_ILLEGAL : CAUSE_STOP;
        end else begin
            if (restart) begin
                st_d.halted = 1'b0;
            end
            if (clr) begin
                st_d.cause = CAUSE_NONE;
            end
        end
        if (mbox_take) begin
            st_d.mbox = 1'b1;
        end else if (clr) begin
            st_d.mbox = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{halted: 1'b0, cause: CAUSE_NONE, mbox: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign halted_o  = st_q.halted;
    assign cause_o   = st_q.cause;
    assign mbox_o    = st_q.mbox;
    assign exc_now_o = exc_take;
endmodule

// File: rtl/evt_stop_ctrl.sv
module evt_stop_ctrl
    import evc_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter int PC_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               wait_i,
    output logic               stall_o,
    output logic               redirect_o,
    output logic [PC_W-1:0]    redirect_pc_o,
    input  logic               illegal_i,
    input  logic               stop_i,
    input  logic               mbox_i,
    output logic               halt_o,
    output logic               irq_o
);
    localparam logic [PC_W-1:0] VECTOR_PC = '0;

    logic [NUM_EVT-1:0] pend_w;
    logic [NUM_EVT-1:0] mask_w;
    logic               int_en_w;
    logic               hit_w;
    logic               take_w;
    logic               halted_w;
    cause_e             cause_w;
    logic               mbox_w;
    logic               exc_now_w;
    logic               unused_wdata;

    logic we_mask, we_ack, we_ctrl, we_stat;

    assign we_mask      = reg_wr && (reg_addr == ADDR_MASK);
    assign we_ack       = reg_wr && (reg_addr == ADDR_ACK);
    assign we_ctrl      = reg_wr && (reg_addr == ADDR_CTRL);
    assign we_stat      = reg_wr && (reg_addr == ADDR_STAT);
    assign unused_wdata = ^reg_wdata;

    evc_event_bank #(.NUM_EVT(NUM_EVT)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_in     (evt_in),
        .mask_we    (we_mask),
        .mask_wdata (reg_wdata[NUM_EVT-1:0]),
        .ack_we     (we_ack),
        .ack_wdata  (reg_wdata[NUM_EVT-1:0]),
        .ie_we      (we_ctrl),
        .ie_wdata   (reg_wdata[0]),
        .halted     (halted_w),
        .pend_o     (pend_w),
        .mask_o     (mask_w),
        .int_en_o   (int_en_w),
        .hit_o      (hit_w),
        .take_o     (take_w)
    );

    evc_stop_unit u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .illegal_i (illegal_i),
        .stop_i    (stop_i),
        .mbox_i    (mbox_i),
        .restart   (we_stat && reg_wdata[ST_RESTART]),
        .clr       (we_stat && reg_wdata[ST_CLEAR]),
        .halted_o  (halted_w),
        .cause_o   (cause_w),
        .mbox_o    (mbox_w),
        .exc_now_o (exc_now_w)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_MASK: reg_rdata[NUM_EVT-1:0] = mask_w;
            ADDR_PEND: reg_rdata[NUM_EVT-1:0] = pend_w;
            ADDR_CTRL: reg_rdata[0]           = int_en_w;
            ADDR_STAT: begin
                reg_rdata[ST_STOPPED]            = halted_w;
                reg_rdata[ST_CAUSE+1:ST_CAUSE]   = cause_w;
                reg_rdata[ST_MBOX]               = mbox_w;
            end
            default:   reg_rdata = '0;
        endcase
    end

    assign stall_o       = wait_i & ~hit_w;
    assign redirect_o    = take_w;
    assign redirect_pc_o = VECTOR_PC;
    assign halt_o        = halted_w | exc_now_w;
    assign irq_o         = (cause_w != CAUSE_NONE) | mbox_w;
endmodule

// File: rtl/evt_stop_ctrl_chk.sv
module evt_stop_ctrl_chk #(
    parameter int NUM_EVT = 8,
    parameter int PC_W    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_in,
    input logic               wait_i,
    input logic               stall_o,
    input logic               redirect_o,
    input logic [PC_W-1:0]    redirect_pc_o,
    input logic               illegal_i,
    input logic               stop_i,
    input logic               mbox_i,
    input logic               halt_o,
    input logic               irq_o,
    input logic [NUM_EVT-1:0] pend,
    input logic [NUM_EVT-1:0] mask,
    input logic               int_en,
    input logic               halted,
    input logic [1:0]         cause
);
    // R1: an event is never lost, even against an acknowledge
    a_r1_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((pend & $past(evt_in)) == $past(evt_in)));

    // R3: a stall only while waiting with nothing enabled pending
    a_r3_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (wait_i && ((pend & mask) == '0)));

    // R6: vector is address zero
    a_r6_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (redirect_pc_o == '0));

    // R6: taking the vector drops the enable
    a_r6_ie_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !int_en);

    // R6: a halted core is not redirected
    a_r6_no_redirect_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !redirect_o);

    // R7: an illegal instruction halts in the same cycle
    a_r7_halt_now: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_i |-> halt_o);

    // R7: and is recorded with cause 1
    a_r7_cause_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_i && !halted) |=> (halted && cause == 2'd1));

    // R8: stop-and-signal alone records cause 2
    a_r8_cause_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !illegal_i && !halted) |=> (halted && cause == 2'd2));

    // R9: a mailbox write does not stop a running core
    a_r9_mbox_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_i && !halted && !illegal_i && !stop_i) |=> (!halted && irq_o));

    // R10: the host request follows a recorded cause
    a_r10_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cause != 2'd0) |-> irq_o);
endmodule

bind evt_stop_ctrl evt_stop_ctrl_chk #(.NUM_EVT(NUM_EVT), .PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_in        (evt_in),
    .wait_i        (wait_i),
    .stall_o       (stall_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .illegal_i     (illegal_i),
    .stop_i        (stop_i),
    .mbox_i        (mbox_i),
    .halt_o        (halt_o),
    .irq_o         (irq_o),
    .pend          (pend_w),
    .mask          (mask_w),
    .int_en        (int_en_w),
    .halted        (halted_w),
    .cause         (cause_w)
);

// File: tb/evt_stop_ctrl_test.sv
module evt_stop_ctrl_test;
    localparam int N   = 8;
    localparam int PCW = 16;

    localparam int K_RDATA = 0;
    localparam int K_STALL = 1;
    localparam int K_REDIR = 2;
    localparam int K_HALT  = 3;
    localparam int K_IRQ   = 4;
    localparam int K_PC    = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   evt_in = '0;
    logic           reg_wr = 1'b0;
    logic [2:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           wait_i = 1'b0;
    logic           stall_o;
    logic           redirect_o;
    logic [PCW-1:0] redirect_pc_o;
    logic           illegal_i = 1'b0;
    logic           stop_i = 1'b0;
    logic           mbox_i = 1'b0;
    logic           halt_o;
    logic           irq_o;

    always #4 clk = ~clk;

    evt_stop_ctrl #(.NUM_EVT(N), .PC_W(PCW)) uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wait_i(wait_i), .stall_o(stall_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .illegal_i(illegal_i), .stop_i(stop_i), .mbox_i(mbox_i),
        .halt_o(halt_o), .irq_o(irq_o)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_cmp  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_RDATA: act = reg_rdata;
                K_STALL: act = {31'd0, stall_o};
                K_REDIR: act = {31'd0, redirect_o};
                K_HALT:  act = {31'd0, halt_o};
                K_IRQ:   act = {31'd0, irq_o};
                default: act = {16'd0, redirect_pc_o};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_v(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic expect_reg(logic [2:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        expect_v(K_RDATA, exp, tag);
    endtask

    task automatic write_reg(logic [2:0] a, logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        tick();
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic pulse_evt(logic [N-1:0] e);
        evt_in = e;
        tick();
        evt_in = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;

        // R12 reset state
        expect_reg(3'd0, 32'h0, "R12 mask");
        tick();
        expect_reg(3'd1, 32'h0, "R12 pending");
        expect_v(K_STALL, 0, "R12 stall");
        expect_v(K_REDIR, 0, "R12 redirect");
        expect_v(K_HALT, 0, "R12 halt");
        expect_v(K_IRQ, 0, "R12 irq");
        tick();
        expect_reg(3'd3, 32'h0, "R12 ctrl");
        tick();
        expect_reg(3'd4, 32'h0, "R12 status");
        tick();

        // R3 mask register
        write_reg(3'd0, 32'h05);
        expect_reg(3'd0, 32'h05, "R3 mask readback");
        wait_i = 1'b1;
        expect_v(K_STALL, 1, "R3 stall with none pending");
        tick();
        pulse_evt(8'h02);
        expect_v(K_STALL, 1, "R3 masked event keeps stall");
        expect_reg(3'd1, 32'h02, "R5 poll shows masked pending");
        tick();
        expect_reg(3'd1, 32'h02, "R1 pending still set");
        evt_in = 8'h04;
        expect_v(K_STALL, 1, "R4 stall in event cycle");
        tick();
        evt_in = '0;
        expect_v(K_STALL, 0, "R4 released next cycle");
        wait_i = 1'b0;
        tick();

        // R2 ack, event in same cycle wins
        evt_in = 8'h02;
        write_reg(3'd2, 32'h06);
        evt_in = '0;
        expect_reg(3'd1, 32'h02, "R2 event beats ack");
        tick();
        expect_reg(3'd2, 32'h0, "R2 ack reads zero");
        tick();

        // R3 unmasking a pending event lifts the stall
        write_reg(3'd0, 32'h01);
        wait_i = 1'b1;
        expect_v(K_STALL, 1, "R3 stall bit1 masked");
        write_reg(3'd0, 32'h03);
        expect_v(K_STALL, 0, "R3 mask change lifts stall");
        wait_i = 1'b0;
        write_reg(3'd2, 32'h02);
        expect_reg(3'd1, 32'h0, "R2 ack clears");
        tick();

        // R6 vectoring
        write_reg(3'd3, 32'h1);
        expect_reg(3'd3, 32'h1, "R6 enable readback");
        expect_v(K_REDIR, 0, "R6 no redirect without event");
        pulse_evt(8'h01);
        expect_v(K_REDIR, 1, "R6 redirect");
        expect_v(K_PC, 0, "R6 vector zero");
        tick();
        expect_v(K_REDIR, 0, "R6 single redirect");
        expect_reg(3'd3, 32'h0, "R6 enable auto clear");
        tick();
        write_reg(3'd2, 32'h01);
        write_reg(3'd3, 32'h1);
        pulse_evt(8'h08);
        expect_v(K_REDIR, 0, "R6 masked event no redirect");
        expect_reg(3'd1, 32'h08, "R5 masked pending");
        tick();
        write_reg(3'd2, 32'h08);

        // R7 illegal instruction
        illegal_i = 1'b1;
        expect_v(K_HALT, 1, "R7 halt same cycle");
        tick();
        illegal_i = 1'b0;
        expect_v(K_HALT, 1, "R7 halt held");
        expect_v(K_IRQ, 1, "R7 irq");
        expect_reg(3'd4, 32'h3, "R7 status");
        tick();
        stop_i = 1'b1;
        tick();
        stop_i = 1'b0;
        expect_reg(3'd4, 32'h3, "R11 cause kept while halted");
        tick();
        pulse_evt(8'h01);
        expect_v(K_REDIR, 0, "R6 halted no redirect");
        tick();
        write_reg(3'd2, 32'h01);

        // R10 restart then clear
        write_reg(3'd4, 32'h10);
        expect_v(K_HALT, 0, "R10 restart");
        expect_v(K_IRQ, 1, "R10 irq held after restart");
        expect_reg(3'd4, 32'h2, "R10 cause kept");
        tick();
        write_reg(3'd4, 32'h20);
        expect_v(K_IRQ, 0, "R10 irq cleared");
        expect_reg(3'd4, 32'h0, "R10 status cleared");
        tick();
        write_reg(3'd3, 32'h0);

        // R8 stop-and-signal
        stop_i = 1'b1;
        expect_v(K_HALT, 1, "R8 halt same cycle");
        tick();
        stop_i = 1'b0;
        expect_reg(3'd4, 32'h5, "R8 status cause 2");
        tick();
        write_reg(3'd4, 32'h30);
        expect_reg(3'd4, 32'h0, "R10 restart and clear");
        tick();
        illegal_i = 1'b1;
        stop_i    = 1'b1;
        tick();
        illegal_i = 1'b0;
        stop_i    = 1'b0;
        expect_reg(3'd4, 32'h3, "R8 illegal has priority");
        tick();
        write_reg(3'd4, 32'h30);

        // R9 mailbox
        mbox_i = 1'b1;
        tick();
        mbox_i = 1'b0;
        expect_v(K_HALT, 0, "R9 no halt");
        expect_v(K_IRQ, 1, "R9 irq");
        expect_reg(3'd4, 32'h8, "R9 status bit3");
        tick();
        write_reg(3'd4, 32'h20);
        expect_v(K_IRQ, 0, "R9 cleared");
        tick();

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule